// File: doc/BRIEF.md
# Scan Test Clock Control Unit

This block governs the clocks of seven internal clock domains while a chip is under scan test or functional debug. A small control register sits behind a dedicated test access port instruction. It is filled serially and committed in parallel, and its committed value decides three things: whether each domain runs from its own functional clock or from one external test clock, which single domain may pulse during a capture step, and whether the processor domains are frozen while the peripheral domains keep running.

Each domain clock passes through a source multiplexer and then a latch-based gate. The gate's enable is sampled only while the source clock is low, so the gated clock never carries a shortened pulse. Once the test-mode bit is set, the scan-enable input chooses between shift behaviour, where every domain pulses together, and capture behaviour, where at most one domain pulses. Between consecutive domain scan chains, a lockup stage samples on the falling edge of the source domain's gated clock. This keeps a chain boundary that crosses clock trees from racing.

Top module: `scan_clk_ctrl`

## Requirements
- R1: After a synchronous active-high reset on `rst` (sampled on `tck`), every domain runs its functional clock, no processor stop is active, and the committed control word reads back as 5'b11100: test mode 0, stop 0, capture index 7.
- R2: The control word is 5 bits: bit 0 is test mode, bit 1 is processor stop, and bits 4:2 are the capture index. With `tap_sel` high, `tap_capture` loads the committed word into the shift stage. Each `tap_shift` cycle then moves `tdi` into bit 4 and shifts right. `tdo` always shows bit 0 of the shift stage, so the word is read LSB first.
- R3: The committed controls change only on a `tck` edge with both `tap_sel` and `tap_update` high. Shifting without an update, or any sequence with `tap_sel` low, leaves the domain clocks unchanged.
- R4: With test mode set, every enabled domain clock follows `test_clk` instead of its functional clock.
- R5: With test mode set and `scan_en` high, all seven domain clocks pulse.
- R6: With test mode set and `scan_en` low, only the domain whose number equals the capture index pulses. An index of 7 gates every domain off.
- R7: With test mode clear and processor stop set, the domains flagged in `CPU_MASK` (default: domains 0 and 1) are held low and the other domains keep running.
- R8: With test mode clear, `scan_en` has no effect on any domain clock.
- R9: Lockup output `lock_so[i]` takes `chain_so[i]` on a falling edge of `dom_clk[i]` and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test access port clock; clocks the control register |
| rst | input | 1 | Synchronous active-high reset, sampled on `tck` |
| tap_sel | input | 1 | The clock-control instruction is the current instruction |
| tap_capture | input | 1 | Capture-DR state |
| tap_shift | input | 1 | Shift-DR state |
| tap_update | input | 1 | Update-DR state |
| tdi | input | 1 | Serial data into the control register |
| tdo | output | 1 | Serial data out of the control register |
| scan_en | input | 1 | Shift (1) or capture (0); acts only while test mode is set |
| test_clk | input | 1 | External test clock |
| func_clk | input | 7 | Functional clock of each domain |
| chain_so | input | 7 | Scan-chain output of each domain |
| dom_clk | output | 7 | Gated clock of each domain |
| lock_so | output | 6 | Lockup-stage output feeding the chain of domain i+1 |

## Verification
On every `tck` edge, the assertions check the gate enables against the committed mode. In shift they must all be set, in capture at most one may be set, and under a processor stop the processor enables must be clear. The assertions also check that the committed word stays fixed without an update and that shifting moves `tdi` into the top bit. Other properties can only be shown by the bench's scenarios. These are the actual clock source behind each domain (measured by counting pulses against `test_clk` and each functional clock), the readback order on `tdo`, the falling-edge timing and hold behaviour of the lockup stages, and the lack of any effect from unselected or non-updated shifting.

// File: rtl/scan_clk_pkg.sv
package scan_clk_pkg;
  localparam int N_DOM = 7;
  localparam int IDX_W = 3;

  typedef struct packed {
    logic [IDX_W-1:0] cap_idx;
    logic             cpu_stop;
    logic             test_mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{cap_idx: '1, cpu_stop: 1'b0, test_mode: 1'b0};
endpackage

// File: rtl/sccu_ctrl_reg.sv
module sccu_ctrl_reg
  import scan_clk_pkg::*;
(
  input  logic  tck,
  input  logic  rst,
  input  logic  sel,
  input  logic  capture,
  input  logic  shift,
  input  logic  update,
  input  logic  tdi,
  output logic  tdo,
  output ctrl_t ctrl
);
  logic [CTRL_W-1:0] shift_q;
  ctrl_t             shadow_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      shift_q <= '0;
    end else if (sel && capture) begin
      shift_q <= shadow_q;
    end else if (sel && shift) begin
      shift_q <= {tdi, shift_q[CTRL_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      shadow_q <= CTRL_RST;
    end else if (sel && update) begin
      shadow_q <= ctrl_t'(shift_q);
    end
  end

  assign tdo  = shift_q[0];
  assign ctrl = shadow_q;

  AST_HOLD_NO_UPDATE: assert property (@(posedge tck) disable iff (rst)
    !(sel && update) |=> $stable(shadow_q)); // R3

  AST_SHIFT_IN_TOP: assert property (@(posedge tck) disable iff (rst)
    (sel && shift && !capture) |=> (shift_q[CTRL_W-1] == $past(tdi))); // R2
endmodule

// File: rtl/sccu_enable.sv
module sccu_enable
  import scan_clk_pkg::*;
#(
  parameter int            N        = N_DOM,
  parameter logic [N-1:0]  CPU_MASK = 7'b0000011
)(
  input  logic         tck,
  input  logic         rst,
  input  ctrl_t        ctrl,
  input  logic         scan_en,
  output logic [N-1:0] en
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (ctrl.test_mode) begin
        en[i] = scan_en || (IDX_W'(i) == ctrl.cap_idx);
      end else begin
        en[i] = !(ctrl.cpu_stop && CPU_MASK[i]);
      end
    end
  end

  AST_SHIFT_ALL: assert property (@(posedge tck) disable iff (rst)
    (ctrl.test_mode && scan_en) |-> (&en)); // R5

  AST_ONE_CAPTURE: assert property (@(posedge tck) disable iff (rst)
    (ctrl.test_mode && !scan_en) |-> $onehot0(en)); // R6

  AST_CPU_STOP: assert property (@(posedge tck) disable iff (rst)
    (!ctrl.test_mode && ctrl.cpu_stop) |-> ((en & CPU_MASK) == '0)); // R7

  AST_FUNC_PERIPH: assert property (@(posedge tck) disable iff (rst)
    !ctrl.test_mode |-> ((en | CPU_MASK) == '1)); // R8
endmodule

// File: rtl/sccu_clk_gate.sv
module sccu_clk_gate (
  input  logic func_clk,
  input  logic test_clk,
  input  logic use_test,
  input  logic en,
  output logic gclk
);
  logic src_clk;
  logic en_l;

  assign src_clk = use_test ? test_clk : func_clk;

  always_latch begin
    if (!src_clk) en_l = en;
  end

  assign gclk = src_clk & en_l;
endmodule

// File: rtl/sccu_lockup.sv
module sccu_lockup (
  input  logic gclk,
  input  logic d,
  output logic q
);
  always_ff @(negedge gclk) begin
    q <= d;
  end
endmodule

// File: rtl/scan_clk_ctrl.sv
module scan_clk_ctrl
  import scan_clk_pkg::*;
#(
  parameter int           N        = N_DOM,
  parameter logic [N-1:0] CPU_MASK = 7'b0000011
)(
  input  logic         tck,
  input  logic         rst,
  input  logic         tap_sel,
  input  logic         tap_capture,
  input  logic         tap_shift,
  input  logic         tap_update,
  input  logic         tdi,
  output logic         tdo,
  input  logic         scan_en,
  input  logic         test_clk,
  input  logic [N-1:0] func_clk,
  input  logic [N-1:0] chain_so,
  output logic [N-1:0] dom_clk,
  output logic [N-2:0] lock_so
);
  ctrl_t        ctrl;
  logic [N-1:0] en;

  sccu_ctrl_reg u_reg (
    .tck     (tck),
    .rst     (rst),
    .sel     (tap_sel),
    .capture (tap_capture),
    .shift   (tap_shift),
    .update  (tap_update),
    .tdi     (tdi),
    .tdo     (tdo),
    .ctrl    (ctrl)
  );

  sccu_enable #(.N(N), .CPU_MASK(CPU_MASK)) u_en (
    .tck     (tck),
    .rst     (rst),
    .ctrl    (ctrl),
    .scan_en (scan_en),
    .en      (en)
  );

  for (genvar g = 0; g < N; g++) begin : g_dom
    sccu_clk_gate u_gate (
      .func_clk (func_clk[g]),
      .test_clk (test_clk),
      .use_test (ctrl.test_mode),
      .en       (en[g]),
      .gclk     (dom_clk[g])
    );
  end

  for (genvar g = 0; g < N - 1; g++) begin : g_lock
    sccu_lockup u_lock (
      .gclk (dom_clk[g]),
      .d    (chain_so[g]),
      .q    (lock_so[g])
    );
  end
endmodule

// File: tb/scan_clk_ctrl_tb.sv
module scan_clk_ctrl_tb;
  localparam int N = 7;
  localparam logic [N-1:0] CPU_MASK = 7'b0000011;

  logic tck = 0, rst = 1, tap_sel = 0, tap_capture = 0, tap_shift = 0, tap_update = 0, tdi = 0;
  logic tdo, scan_en = 0, test_clk = 0;
  logic [N-1:0] func_clk = '0, chain_so = '0, dom_clk;
  logic [N-2:0] lock_so;

  int checks = 0, errors = 0;
  logic win = 0;
  int cnt [N];
  int fcnt [N];
  int tcnt;

  scan_clk_ctrl #(.N(N), .CPU_MASK(CPU_MASK)) u_dut (
    .tck(tck), .rst(rst), .tap_sel(tap_sel), .tap_capture(tap_capture),
    .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi), .tdo(tdo),
    .scan_en(scan_en), .test_clk(test_clk), .func_clk(func_clk),
    .chain_so(chain_so), .dom_clk(dom_clk), .lock_so(lock_so)
  );

  always #5 tck = ~tck;
  always #7 test_clk = ~test_clk;
  for (genvar g = 0; g < N; g++) begin : g_clk
    initial forever #(2 + 3 * g) func_clk[g] = ~func_clk[g];
    always @(posedge dom_clk[g])  if (win) cnt[g]++;
    always @(posedge func_clk[g]) if (win) fcnt[g]++;
  end
  always @(posedge test_clk) if (win) tcnt++;

  // vector: {ctrl[4:0] = {idx,stop,test}, scan_en, expected running mask}
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {5'b11100, 1'b0, 7'b1111111},  // R1 functional, all run
    {5'b11110, 1'b0, 7'b1111100},  // R7 processor stop
    {5'b11110, 1'b1, 7'b1111100},  // R8 scan_en ignored
    {5'b11101, 1'b1, 7'b1111111},  // R5 R4 shift all
    {5'b01001, 1'b0, 7'b0000100},  // R6 capture domain 2
    {5'b11001, 1'b0, 7'b1000000},  // R6 capture domain 6
    {5'b11101, 1'b0, 7'b0000000},  // R6 index 7 none
    {5'b00001, 1'b0, 7'b0000001},  // R6 capture domain 0
    {5'b00000, 1'b1, 7'b1111111}   // R8 functional with scan_en
  };

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic load(input logic [4:0] v, input bit sel, input bit upd, output logic [4:0] rb);
    @(negedge tck); tap_sel = sel; tap_capture = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge tck); tap_capture = 0; tap_shift = 1; tdi = v[k]; rb[k] = tdo;
    end
    @(negedge tck); tap_shift = 0; tap_update = upd;
    @(negedge tck); tap_update = 0; tap_sel = 0;
  endtask

  task automatic measure(input logic [4:0] ctl, input logic [N-1:0] exp, input string req);
    logic [N-1:0] run;
    bit ok;
    int ref_c;
    repeat (5) @(negedge tck);
    for (int i = 0; i < N; i++) begin cnt[i] = 0; fcnt[i] = 0; end
    tcnt = 0;
    win = 1;
    repeat (40) @(negedge tck);
    win = 0;
    #1;
    ok = 1;
    for (int i = 0; i < N; i++) begin
      run[i] = (cnt[i] != 0);
      ref_c = ctl[0] ? tcnt : fcnt[i];
      if (exp[i] && (cnt[i] > ref_c + 1 || cnt[i] + 1 < ref_c)) ok = 0;  // R4 source
    end
    check(ok && run == exp, req, $sformatf("mask %b", run), $sformatf("mask %b", exp));
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] rb, last;
    repeat (3) @(negedge tck);
    rst = 0;
    // R1 reset state: readback and clocks
    load(5'b11100, 1, 1, rb);
    check(rb == 5'b11100, "R1", $sformatf("%b", rb), "11100");
    measure(5'b11100, 7'b1111111, "R1");
    last = 5'b11100;
    for (int v = 0; v < NV; v++) begin
      load(VEC[v][12:8], 1, 1, rb);
      check(rb == last, "R2 readback", $sformatf("%b", rb), $sformatf("%b", last));
      scan_en = VEC[v][7];
      measure(VEC[v][12:8], VEC[v][6:0], $sformatf("R4-8 vec%0d", v));
      last = VEC[v][12:8];
    end
    // R3: unselected shift, then selected update-only: controls stay
    scan_en = 0;
    load(5'b01001, 0, 0, rb);
    @(negedge tck); tap_sel = 1; tap_update = 1;
    @(negedge tck); tap_sel = 0; tap_update = 0;
    measure(5'b00000, 7'b1111111, "R3 unselected");
    // R3: shift without update
    load(5'b11101, 1, 0, rb);
    measure(5'b00000, 7'b1111111, "R3 no update");
    // R9 lockup: capture domain 2 only
    load(5'b01001, 1, 1, rb);
    repeat (5) @(negedge tck);
    @(posedge test_clk); #1; chain_so = 7'h7F;
    @(negedge test_clk); #1;
    check(lock_so == 6'b000100, "R9 capture", $sformatf("%b", lock_so), "000100");
    scan_en = 1;
    repeat (3) @(negedge test_clk); #1;
    check(lock_so == 6'b111111, "R9 shift", $sformatf("%b", lock_so), "111111");
    chain_so = '0;
    @(posedge test_clk); #1;
    check(lock_so == 6'b111111, "R9 hold", $sformatf("%b", lock_so), "111111");
    @(negedge test_clk); #1;
    check(lock_so == 6'b000000, "R9 fall", $sformatf("%b", lock_so), "000000");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule